// File: doc/BRIEF.md
# Stalling FIFO Write Buffer

The block sits between a processor's cache and a slower main memory and holds writes that have not yet reached memory. Each held write carries an address, a data word and byte enables. The processor hands a write to the buffer in a single clock cycle and carries on executing. The memory side takes the oldest held write through a valid/ready handshake, one at a time, and keeps going until nothing is left.

The only back-pressure on the processor is a stall. The stall is raised when a write is offered while every slot is occupied and no slot is freed in that same cycle. Held data is never forwarded to reads. A read path that needs memory to be current watches the empty flag and waits until the buffer has drained. The depth is a parameter and is kept small; the default is four entries.

Top module: `wbuf_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `buf_empty` is 1, `mem_valid` is 0 and `cpu_stall` is 0, and any entries held before reset are discarded.
- R2: When `cpu_wr_en` is 1 and the buffer is not full, `cpu_stall` is 0 and the write (address, data, byte enables) is stored at that clock edge.
- R3: Writes reach the memory port in strictly the order they were accepted, with address, data and byte enables unchanged.
- R4: `mem_valid` is 1 exactly when at least one entry is held. A write accepted at an edge is presented no earlier than the cycle after that edge, so there is no same-cycle pass-through.
- R5: An entry leaves only in a cycle where `mem_valid` and `mem_ready` are both 1. While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_be` hold their values into the next cycle.
- R6: When the buffer is full, `cpu_wr_en` is 1 and no entry leaves in that cycle, `cpu_stall` is 1 and the offered write is not stored.
- R7: When the buffer is full and an entry leaves in the same cycle that a write is offered, `cpu_stall` is 0 and the write is stored.
- R8: `buf_empty` is 1 exactly when no entry is held.
- R9: The buffer holds exactly DEPTH entries (default 4). With `mem_ready` held at 0, the first DEPTH offered writes are accepted and the next one stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Processor offers a write this cycle |
| cpu_addr | input | AW | Write address |
| cpu_data | input | DW | Write data |
| cpu_be | input | DW/8 | Byte enables of the write |
| cpu_stall | output | 1 | Offered write not taken; processor must hold it |
| mem_valid | output | 1 | Oldest held write is presented |
| mem_ready | input | 1 | Memory takes the presented write |
| mem_addr | output | AW | Address of the oldest held write |
| mem_data | output | DW | Data of the oldest held write |
| mem_be | output | DW/8 | Byte enables of the oldest held write |
| buf_empty | output | 1 | No write is held |

## Verification
The assertions assume two things about the processor side. First, a stalled processor keeps offering the same write until it is taken. Second, `mem_ready` is a plain input that does not combinationally depend on `cpu_stall`, so the loop from ready to stall has no cycle in it. The bench drives both inputs at the falling edge from fixed per-cycle values. It never derives `mem_ready` from the stall it observes. It re-offers a fresh write after every stall, which shows that a stalled offer leaves no trace at the memory port.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Advance a slot index, wrapping back to zero after the last slot.
  function automatic int unsigned slot_after(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one edge, given whether a write entered and one left.
  function automatic int unsigned fill_after(input int unsigned fill, input logic put, input logic take);
    case ({put, take})
      2'b10:   return fill + 1;
      2'b01:   return fill - 1;
      default: return fill;
    endcase
  endfunction

endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl import wbuf_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_ready,
  output logic          wr_accept,
  output logic          rd_fire,
  output logic          stall,
  output logic          empty,
  output logic          full,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr
);

  logic [CW-1:0] fill_q;

  assign full      = (fill_q == CW'(DEPTH));
  assign empty     = (fill_q == '0);
  assign rd_fire   = !empty && rd_ready;
  assign stall     = wr_req && full && !rd_fire;
  assign wr_accept = wr_req && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      fill_q <= CW'(fill_after(int'(fill_q), wr_accept, rd_fire));
      if (wr_accept) wr_ptr <= PW'(slot_after(int'(wr_ptr), DEPTH));
      if (rd_fire)   rd_ptr <= PW'(slot_after(int'(rd_ptr), DEPTH));
    end
  end

  // R9: occupancy never exceeds the parameterised depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));

  // R6: a stall is only raised when every slot is taken
  a_r6_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> full);

  // R6: a stalled cycle leaves the write pointer untouched
  a_r6_stall_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rd_fire) |=> $stable(wr_ptr));

  // R7: a full buffer that drains this cycle takes the offered write
  a_r7_swap_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && rd_fire) |=> full);

  // R4: an accepted write makes the buffer non-empty next cycle
  a_r4_accept_then_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !empty);

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH = 4,
  parameter int EW    = 68,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic [PW-1:0] put_idx,
  input  logic [EW-1:0] put_entry,
  input  logic [PW-1:0] get_idx,
  output logic [EW-1:0] get_entry
);

  logic [EW-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = put && (put_idx == PW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   slot_q[i] <= '0;
      else if (hit) slot_q[i] <= put_entry;
    end
  end

  assign get_entry = slot_q[get_idx];

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW = DW / 8,
  localparam int EW = AW + DW + BW,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_en,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic [BW-1:0] cpu_be,
  output logic          cpu_stall,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [BW-1:0] mem_be,
  output logic          buf_empty
);

  logic          wr_accept;
  logic          rd_fire;
  logic          empty;
  logic          full;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [EW-1:0] head_entry;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (cpu_wr_en),
    .rd_ready  (mem_ready),
    .wr_accept (wr_accept),
    .rd_fire   (rd_fire),
    .stall     (cpu_stall),
    .empty     (empty),
    .full      (full),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
  );

  wbuf_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .put       (wr_accept),
    .put_idx   (wr_ptr),
    .put_entry ({cpu_addr, cpu_data, cpu_be}),
    .get_idx   (rd_ptr),
    .get_entry (head_entry)
  );

  assign mem_valid = !empty;
  assign buf_empty = empty;
  assign {mem_addr, mem_data, mem_be} = head_entry;

  // R5: a blocked presentation is held unchanged into the next cycle
  a_r5_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  // R8: the empty flag and the presented-write flag never disagree
  a_r8_empty_vs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty != mem_valid);

  // R4: from empty, a write offered this cycle is not presented in the same cycle
  a_r4_no_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && cpu_wr_en) |-> !mem_valid);

  // R1: full flag cannot be set right after reset
  a_r1_not_full_after_reset: assert property (@(posedge clk)
    !rst_n |=> !full);

endmodule

// File: tb/wbuf_top_bench.sv
module wbuf_top_bench;

  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr_en = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_data = '0;
  logic [BW-1:0] cpu_be = '0;
  logic          cpu_stall;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [BW-1:0] mem_be;
  logic          buf_empty;

  wbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_wbuf_top (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_be(cpu_be),
    .cpu_stall(cpu_stall),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .buf_empty(buf_empty)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference queue of accepted writes
  logic [AW-1:0] q_addr [32];
  logic [DW-1:0] q_data [32];
  logic [BW-1:0] q_be   [32];
  int q_head = 0;
  int q_tail = 0;
  int seq = 0;

  // {wr, ready, expected stall, expected empty}; depth 4
  localparam logic [3:0] VEC [14] = '{
    4'b1001, 4'b1000, 4'b1000, 4'b1000,
    4'b1010, 4'b1100, 4'b0100, 4'b0100,
    4'b1100, 4'b0100, 4'b0100, 4'b0101,
    4'b1101, 4'b0100
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [BW-1:0] be_of(input logic [AW-1:0] a);
    return a[5:2] | 4'b0001;
  endfunction

  // Drive one cycle at the falling edge, then settle and score the memory port.
  task automatic cycle(input bit wr, input bit rdy);
    logic [AW-1:0] a;
    @(negedge clk);
    a = 32'h0000_1000 + AW'(seq * 4);
    seq++;
    cpu_wr_en = wr;
    cpu_addr  = a;
    cpu_data  = data_of(a);
    cpu_be    = be_of(a);
    mem_ready = rdy;
    #1;
    if (mem_valid && mem_ready) begin
      if (q_head == q_tail) begin
        chk(1'b0, "R3 unexpected write at memory port", longint'(mem_addr), 0);
      end else begin
        chk(mem_addr == q_addr[q_head % 32], "R3 address order", longint'(mem_addr), longint'(q_addr[q_head % 32]));
        chk(mem_data == q_data[q_head % 32], "R3 data", longint'(mem_data), longint'(q_data[q_head % 32]));
        chk(mem_be == q_be[q_head % 32], "R3 byte enables", longint'(mem_be), longint'(q_be[q_head % 32]));
        q_head++;
      end
    end
    if (wr && !cpu_stall) begin
      q_addr[q_tail % 32] = a;
      q_data[q_tail % 32] = data_of(a);
      q_be[q_tail % 32]   = be_of(a);
      q_tail++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(buf_empty == 1'b1, "R1 empty in reset", buf_empty, 1);
    chk(mem_valid == 1'b0, "R1 valid in reset", mem_valid, 0);
    chk(cpu_stall == 1'b0, "R1 stall in reset", cpu_stall, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R2 R4 R6 R7 R8 R9
    for (int i = 0; i < 14; i++) begin
      cycle(VEC[i][3], VEC[i][2]);
      chk(cpu_stall == VEC[i][1], $sformatf("R6/R7 stall vector %0d", i), cpu_stall, VEC[i][1]);
      chk(buf_empty == VEC[i][0], $sformatf("R8 empty vector %0d", i), buf_empty, VEC[i][0]);
      chk(mem_valid == !VEC[i][0], $sformatf("R4 valid vector %0d", i), mem_valid, !VEC[i][0]);
    end
    cycle(1'b0, 1'b0);
    chk(buf_empty == 1'b1, "R8 drained after table", buf_empty, 1);

    // R9: exactly DEPTH writes fit; R5 head holds while blocked; R6 stalled writes dropped
    for (int i = 0; i < DEPTH; i++) begin
      cycle(1'b1, 1'b0);
      chk(cpu_stall == 1'b0, "R9 fill accepted", cpu_stall, 0);
    end
    held = q_addr[q_head % 32];
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 1'b0);
      chk(cpu_stall == 1'b1, "R9 R6 stall when full", cpu_stall, 1);
      chk(mem_addr == held, "R5 head held while blocked", longint'(mem_addr), longint'(held));
    end
    for (int i = 0; i < DEPTH; i++) begin
      cycle(1'b0, 1'b1);
      chk(mem_valid == 1'b1, "R4 valid while draining", mem_valid, 1);
    end
    cycle(1'b0, 1'b1);
    chk(buf_empty == 1'b1 && mem_valid == 1'b0, "R6 stalled writes not stored", buf_empty, 1);
    chk(q_head == q_tail, "R3 all accepted writes seen", q_head, q_tail);

    // R4: no pass-through from empty
    cycle(1'b1, 1'b1);
    chk(mem_valid == 1'b0, "R4 no same-cycle pass-through", mem_valid, 0);
    cycle(1'b0, 1'b0);
    chk(mem_valid == 1'b1, "R4 presented next cycle", mem_valid, 1);
    cycle(1'b0, 1'b1);

    // R1: reset discards held entries
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b0);
    @(negedge clk);
    cpu_wr_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(buf_empty == 1'b1, "R1 reset clears entries", buf_empty, 1);
    chk(mem_valid == 1'b0, "R1 reset clears valid", mem_valid, 0);
    q_head = q_tail;
    cycle(1'b0, 1'b1);
    chk(mem_valid == 1'b0, "R1 nothing left after reset", mem_valid, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule